// File: doc/BRIEF.md
# Gated Internal Register Access Unit

This block executes a small group of special processor instructions that reach six internal configuration registers. These registers are two blit-buffer base registers, two blit-buffer pointer registers, and a power-management base and mask pair. A decoded 16-bit opcode arrives together with an address operand, a write-data operand and a 2-bit scratchpad-size setting. The block answers one cycle later with a done strobe, read data and a descriptor of the internal I/O-space transaction it issued. If the instruction is disabled, it answers with an illegal-opcode trap instead.

The whole group is switched by the scratchpad-size field. When that field is zero, no part of the cache is set aside as scratchpad. Every instruction of the group then traps and leaves all state untouched. Two of the instructions copy a buffer's base into its pointer. The other two move exactly 32 bits between an operand and a register chosen by its full 32-bit address.

Top module: `intreg_gate_unit`

## Requirements
- R1: After a synchronous reset, all six registers hold zero, and done, trap, io_internal, io_addr and rd_data are all zero.
- R2: The group consists of opcodes 16'h0F3A (reload pointer 0), 16'h0F3B (reload pointer 1), 16'h0F3C (register write) and 16'h0F3D (register read). With op_valid high and scratch_size nonzero, each of them produces a done pulse one cycle wide.
- R3: When scratch_size is 2'b00, every opcode in the group raises trap for one cycle. In that case done stays low, no I/O transaction is issued and no register changes.
- R4: A write to 32'hFFFFFF6C (power base) or 32'hFFFFFF7C (power mask) stores all 32 bits of wr_data. A read of the same address then returns those 32 bits on rd_data.
- R5: The buffer registers sit at 32'hFFFFFF0C (base 0), 32'hFFFFFF1C (base 1), 32'hFFFFFF2C (pointer 0) and 32'hFFFFFF3C (pointer 1). Each holds 12 bits. Writes drop wr_data[31:12], and reads return zero in bits 31:12.
- R6: A pointer reload copies the current base of the selected buffer into that buffer's pointer. The pointer of the other buffer is left unchanged.
- R7: A write to any other address changes no register. A read from any other address returns zero with done and no trap.
- R8: Each enabled read or write pulses io_internal together with done. During that pulse, io_addr equals the address operand with bit 31 forced to 1. Pointer reloads and idle cycles leave io_internal and io_addr at zero.
- R9: Opcodes outside the group produce neither done nor trap and change no register.
- R10: done, trap, rd_data and io_* respond in the clock cycle after the one in which op_valid was sampled high. rd_data is zero in every cycle except the done cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 16 | Decoded two-byte opcode |
| addr_opnd | input | 32 | Register address operand |
| wr_data | input | 32 | Source data operand for writes |
| scratch_size | input | 2 | Scratchpad-size field; zero disables the group |
| rd_data | output | 32 | Result of a read, valid with done |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | One-cycle illegal-opcode pulse |
| io_internal | output | 1 | Internal I/O-space transaction issued |
| io_addr | output | 32 | Address of that transaction, bit 31 set |

## Verification
The block is driven with every opcode of the group under each of the three enabling size values, and also under the zero value. This separates correct gating from decoding that ignores the size field. Writes of all-ones and of mixed patterns to the narrow and the wide registers show whether upper bits are dropped only where they should be. Writes to unmapped and near-miss addresses show whether the address decode is complete. Pointer reloads after distinct bases are written to each buffer expose any cross-wiring between the two buffers. Back-to-back instructions, foreign opcodes and idle gaps check that each response is tied to exactly one accepted instruction.

// File: rtl/intreg_pkg.sv
package intreg_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned BUF_W  = 12;
    localparam int unsigned N_BUF  = 2;

    localparam logic [15:0] OPC_PTR0_LOAD = 16'h0F3A;
    localparam logic [15:0] OPC_PTR1_LOAD = 16'h0F3B;
    localparam logic [15:0] OPC_REG_WR    = 16'h0F3C;
    localparam logic [15:0] OPC_REG_RD    = 16'h0F3D;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_BASE0 = 3'd1,
        SEL_BASE1 = 3'd2,
        SEL_PTR0  = 3'd3,
        SEL_PTR1  = 3'd4,
        SEL_PMB   = 3'd5,
        SEL_PMM   = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic             en;
        logic             trap;
        logic             rd;
        logic             wr;
        logic [N_BUF-1:0] ptr_load;
    } cmd_t;

    function automatic reg_sel_e map_addr(input logic [DATA_W-1:0] a);
        case (a)
            32'hFFFF_FF0C: map_addr = SEL_BASE0;
            32'hFFFF_FF1C: map_addr = SEL_BASE1;
            32'hFFFF_FF2C: map_addr = SEL_PTR0;
            32'hFFFF_FF3C: map_addr = SEL_PTR1;
            32'hFFFF_FF6C: map_addr = SEL_PMB;
            32'hFFFF_FF7C: map_addr = SEL_PMM;
            default:       map_addr = SEL_NONE;
        endcase
    endfunction

    function automatic reg_sel_e base_sel(input int b);
        return (b == 0) ? SEL_BASE0 : SEL_BASE1;
    endfunction

    function automatic reg_sel_e ptr_sel(input int b);
        return (b == 0) ? SEL_PTR0 : SEL_PTR1;
    endfunction

endpackage

// File: rtl/intreg_decode.sv
module intreg_decode
    import intreg_pkg::*;
(
    input  logic        op_valid,
    input  logic [15:0] op_code,
    input  logic [1:0]  scratch_size,
    output cmd_t        cmd
);
    logic in_group;
    logic enabled;

    always_comb begin
        in_group = op_valid && (op_code == OPC_PTR0_LOAD || op_code == OPC_PTR1_LOAD ||
                                op_code == OPC_REG_WR    || op_code == OPC_REG_RD);
        enabled  = (scratch_size != 2'b00);

        cmd             = '0;
        cmd.en          = in_group && enabled;
        cmd.trap        = in_group && !enabled;
        cmd.rd          = cmd.en && (op_code == OPC_REG_RD);
        cmd.wr          = cmd.en && (op_code == OPC_REG_WR);
        cmd.ptr_load[0] = cmd.en && (op_code == OPC_PTR0_LOAD);
        cmd.ptr_load[1] = cmd.en && (op_code == OPC_PTR1_LOAD);
    end
endmodule

// File: rtl/intreg_regs.sv
module intreg_regs
    import intreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rval
);
    logic [BUF_W-1:0]  base_q [N_BUF];
    logic [BUF_W-1:0]  ptr_q  [N_BUF];
    logic [DATA_W-1:0] pmb_q;
    logic [DATA_W-1:0] pmm_q;

    for (genvar b = 0; b < N_BUF; b++) begin : g_buf
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[b] <= '0;
                ptr_q[b]  <= '0;
            end else begin
                if (cmd.wr && sel == base_sel(b))
                    base_q[b] <= wdata[BUF_W-1:0];
                if (cmd.ptr_load[b])
                    ptr_q[b] <= base_q[b];
                else if (cmd.wr && sel == ptr_sel(b))
                    ptr_q[b] <= wdata[BUF_W-1:0];
            end
        end

        // R6
        ptr_reload_chk: assert property (@(posedge clk) disable iff (rst)
            cmd.ptr_load[b] |=> ptr_q[b] == $past(base_q[b]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pmb_q <= '0;
            pmm_q <= '0;
        end else if (cmd.wr) begin
            if (sel == SEL_PMB) pmb_q <= wdata;
            if (sel == SEL_PMM) pmm_q <= wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_BASE0: rval = DATA_W'(base_q[0]);
            SEL_BASE1: rval = DATA_W'(base_q[1]);
            SEL_PTR0:  rval = DATA_W'(ptr_q[0]);
            SEL_PTR1:  rval = DATA_W'(ptr_q[1]);
            SEL_PMB:   rval = pmb_q;
            SEL_PMM:   rval = pmm_q;
            default:   rval = '0;
        endcase
    end

    // R3
    trap_keeps_pm_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.trap |=> pmb_q == $past(pmb_q) && pmm_q == $past(pmm_q));
endmodule

// File: rtl/intreg_gate_unit.sv
module intreg_gate_unit
    import intreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [15:0] op_code,
    input  logic [31:0] addr_opnd,
    input  logic [31:0] wr_data,
    input  logic [1:0]  scratch_size,
    output logic [31:0] rd_data,
    output logic        done,
    output logic        trap,
    output logic        io_internal,
    output logic [31:0] io_addr
);
    cmd_t              cmd;
    reg_sel_e          sel;
    logic [DATA_W-1:0] rval;
    logic              access;

    assign sel    = map_addr(addr_opnd);
    assign access = cmd.rd || cmd.wr;

    intreg_decode u_decode (
        .op_valid     (op_valid),
        .op_code      (op_code),
        .scratch_size (scratch_size),
        .cmd          (cmd)
    );

    intreg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .sel   (sel),
        .wdata (wr_data),
        .rval  (rval)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done        <= 1'b0;
            trap        <= 1'b0;
            rd_data     <= '0;
            io_internal <= 1'b0;
            io_addr     <= '0;
        end else begin
            done        <= cmd.en;
            trap        <= cmd.trap;
            rd_data     <= cmd.rd ? rval : '0;
            io_internal <= access;
            io_addr     <= access ? {1'b1, addr_opnd[30:0]} : '0;
        end
    end

    // R3
    done_trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && trap));

    // R3
    trap_cause_chk: assert property (@(posedge clk) disable iff (rst)
        trap |-> $past(scratch_size) == 2'b00);

    // R10
    resp_after_op_chk: assert property (@(posedge clk) disable iff (rst)
        (done || trap) |-> $past(op_valid));

    // R8
    io_flag_chk: assert property (@(posedge clk) disable iff (rst)
        io_internal |-> (done && io_addr[31]));
endmodule

// File: tb/intreg_gate_unit_tb_top.sv
module intreg_gate_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [15:0] op_code = '0;
    logic [31:0] addr_opnd = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  scratch_size = 2'b01;
    logic [31:0] rd_data;
    logic        done, trap, io_internal;
    logic [31:0] io_addr;

    int tests = 0;
    int fails = 0;

    logic [31:0] mdl [6];
    logic        e_done, e_trap, e_io;
    logic [31:0] e_rdata, e_ioaddr;
    string       cur_tag = "R1";

    always #10 clk = ~clk;

    intreg_gate_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .addr_opnd(addr_opnd), .wr_data(wr_data), .scratch_size(scratch_size),
        .rd_data(rd_data), .done(done), .trap(trap),
        .io_internal(io_internal), .io_addr(io_addr)
    );

    function automatic int idx_of(input logic [31:0] a);
        if (a == 32'hFFFFFF0C) return 0;
        if (a == 32'hFFFFFF1C) return 1;
        if (a == 32'hFFFFFF2C) return 2;
        if (a == 32'hFFFFFF3C) return 3;
        if (a == 32'hFFFFFF6C) return 4;
        if (a == 32'hFFFFFF7C) return 5;
        return -1;
    endfunction

    task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cur_tag, "done", 32'(done), 32'(e_done));
        chk(cur_tag, "trap", 32'(trap), 32'(e_trap));
        chk(cur_tag, "rd_data", rd_data, e_rdata);
        chk(cur_tag, "io_internal", 32'(io_internal), 32'(e_io));
        chk(cur_tag, "io_addr", io_addr, e_ioaddr);
    endtask

    task automatic step(input logic v, input logic [15:0] op, input logic [31:0] a,
                        input logic [31:0] d, input logic [1:0] sz, input string tag);
        logic grp, en, rdop, wrop;
        int   ix;
        @(negedge clk);
        compare_all();
        op_valid = v; op_code = op; addr_opnd = a; wr_data = d; scratch_size = sz;
        cur_tag = tag;
        grp  = v && (op == 16'h0F3A || op == 16'h0F3B || op == 16'h0F3C || op == 16'h0F3D);
        en   = grp && (sz != 2'b00);
        rdop = en && op == 16'h0F3D;
        wrop = en && op == 16'h0F3C;
        ix   = idx_of(a);
        e_done   = en;
        e_trap   = grp && !en;
        e_io     = rdop || wrop;
        e_ioaddr = (rdop || wrop) ? (a | 32'h8000_0000) : 32'h0;
        e_rdata  = (rdop && ix >= 0) ? mdl[ix] : 32'h0;
        if (wrop && ix >= 0) mdl[ix] = (ix < 4) ? (d & 32'h0000_0FFF) : d;
        if (en && op == 16'h0F3A) mdl[2] = mdl[0];
        if (en && op == 16'h0F3B) mdl[3] = mdl[1];
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] sz, input string tag);
        step(1'b1, 16'h0F3D, a, 32'h0, sz, tag);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz, input string tag);
        step(1'b1, 16'h0F3C, a, d, sz, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 16'h0, 32'h0, 32'h0, 2'b01, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) mdl[i] = '0;
        e_done = 0; e_trap = 0; e_io = 0; e_rdata = 0; e_ioaddr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, all registers read zero
        idle("R1");
        rd(32'hFFFFFF0C, 2'b01, "R1");
        rd(32'hFFFFFF1C, 2'b01, "R1");
        rd(32'hFFFFFF2C, 2'b01, "R1");
        rd(32'hFFFFFF3C, 2'b01, "R1");
        rd(32'hFFFFFF6C, 2'b01, "R1");
        rd(32'hFFFFFF7C, 2'b01, "R1");

        // R4: 32-bit power registers
        wr(32'hFFFFFF6C, 32'hDEADBEEF, 2'b10, "R4");
        wr(32'hFFFFFF7C, 32'hF0F0_0F0F, 2'b11, "R4");
        rd(32'hFFFFFF6C, 2'b10, "R4");
        rd(32'hFFFFFF7C, 2'b01, "R4");

        // R5: 12-bit buffer registers
        wr(32'hFFFFFF0C, 32'hFFFFFFFF, 2'b01, "R5");
        wr(32'hFFFFFF3C, 32'h12345ABC, 2'b10, "R5");
        rd(32'hFFFFFF0C, 2'b01, "R5");
        rd(32'hFFFFFF3C, 2'b11, "R5");

        // R6: pointer reloads with distinct bases
        wr(32'hFFFFFF1C, 32'h000002A5, 2'b01, "R6");
        wr(32'hFFFFFF2C, 32'h00000777, 2'b01, "R6");
        step(1'b1, 16'h0F3B, 32'h0, 32'h0, 2'b11, "R6");
        rd(32'hFFFFFF3C, 2'b01, "R6");
        rd(32'hFFFFFF2C, 2'b01, "R6");
        step(1'b1, 16'h0F3A, 32'h0, 32'h0, 2'b10, "R6");
        rd(32'hFFFFFF2C, 2'b01, "R6");
        rd(32'hFFFFFF3C, 2'b01, "R6");

        // R3: scratch size zero traps every opcode
        wr(32'hFFFFFF6C, 32'h11111111, 2'b00, "R3");
        wr(32'hFFFFFF0C, 32'h00000123, 2'b00, "R3");
        step(1'b1, 16'h0F3A, 32'h0, 32'h0, 2'b00, "R3");
        step(1'b1, 16'h0F3B, 32'h0, 32'h0, 2'b00, "R3");
        rd(32'hFFFFFF6C, 2'b00, "R3");
        rd(32'hFFFFFF6C, 2'b01, "R3");
        rd(32'hFFFFFF0C, 2'b01, "R3");
        wr(32'hFFFFFF2C, 32'h00000555, 2'b01, "R3");
        step(1'b1, 16'h0F3A, 32'h0, 32'h0, 2'b00, "R3");
        rd(32'hFFFFFF2C, 2'b01, "R3");

        // R7: unmapped addresses
        wr(32'hFFFFFF4C, 32'hCAFEF00D, 2'b01, "R7");
        wr(32'hFFFFFF6D, 32'h00000000, 2'b01, "R7");
        rd(32'hFFFFFF4C, 2'b01, "R7");
        rd(32'h0000000C, 2'b10, "R7");
        rd(32'hFFFFFF6C, 2'b01, "R7");

        // R9: foreign opcodes
        step(1'b1, 16'h0F3E, 32'hFFFFFF6C, 32'h0, 2'b01, "R9");
        step(1'b1, 16'h0F39, 32'hFFFFFF6C, 32'h0, 2'b00, "R9");
        step(1'b1, 16'h1F3C, 32'hFFFFFF6C, 32'h77777777, 2'b01, "R9");
        rd(32'hFFFFFF6C, 2'b01, "R9");

        // R8: io transaction on access, none on reload; R2 back-to-back
        wr(32'h7FFFFF7C, 32'h00000001, 2'b01, "R8");
        step(1'b1, 16'h0F3B, 32'h0, 32'h0, 2'b01, "R8");
        rd(32'hFFFFFF7C, 2'b11, "R2");
        wr(32'hFFFFFF7C, 32'hA5A5A5A5, 2'b10, "R2");
        rd(32'hFFFFFF7C, 2'b10, "R2");

        // R10: idle gaps, response only in the cycle after an op
        idle("R10");
        rd(32'hFFFFFF0C, 2'b01, "R10");
        idle("R10");
        idle("R10");
        step(1'b0, 16'h0F3D, 32'hFFFFFF6C, 32'h0, 2'b01, "R10");
        idle("R10");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule